// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block decides which of up to eight output queues belonging to a single port is allowed to send next. Each queue is programmed with a weight level. A queue at the special static level is served ahead of all others. All remaining queues share service by round-robin. Each of them takes part only in the rounds its 8-bit participation mask enables. The queue list starts at queue 0 and ends at the first queue whose end-of-list flag is set. Queues after that point are ignored.

Each queue raises a request bit while it has work. Every pulse on `next_i` produces one decision. The decision appears one cycle later as a grant strobe with a queue index. If no queue is eligible, the strobe stays low. Weights are written through a single-cycle write port and may change between decisions while the scheduler runs. A write that would break the static-group rule, or that carries an unknown level, is rejected and flagged.

Top module: `wrr_queue_sched`

## Requirements
- R1: After reset, `gnt_valid_o` and `cfg_err_o` are 0. Every queue is at level 0 and non-static. No end-of-list flag is set. The round counter and the search start are both 0. A decision with all queues requesting therefore yields no grant.
- R2: A write with `cfg_level_i` = L stores an 8-bit participation mask for the queue: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f, 8→0xff. Mask bit r enables the queue in round r. Level 9 makes the queue static, with an all-ones mask. `cfg_tail_i`=1 marks the queue as the last one in the list. Over the eight rounds, a level-L queue paired with an always-requesting level-8 queue receives L of every L+8 grants.
- R3: A grant names only a queue whose `req_i` bit was 1 at the decision edge and which lies at or before the first queue with its end-of-list flag set.
- R4: `next_i` is sampled at a rising edge. `gnt_valid_o` is 1 during the following cycle only, with `gnt_idx_o` valid then. With no eligible queue, `gnt_valid_o` stays 0 and the round state is kept.
- R5: A requesting static queue always wins over the round-robin queues. Among static queues, the lowest index wins. A static grant leaves the round counter and the search start unchanged.
- R6: The static queues must form a contiguous group starting at queue 0. A write that would leave them otherwise, or that has a level above 9, sets `cfg_err_o` for the next cycle and changes nothing. A valid write clears `cfg_err_o`.
- R7: In the current round r, the search covers indices from the search start upward. If nothing is found, it continues with rounds r+1, r+2, … (modulo 8), each from index 0. Finally it checks round r below the search start. A grant moves the round counter to the round it was found in and the start to the next index. A grant to index 7 resets the start to 0 and advances the round.
- R8: A queue at level 0 is never granted, even as the only requester. A weight change takes effect at the first decision after the write, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 3 | Queue index for the write |
| cfg_level_i | input | 4 | Weight level 0..8, or 9 for static |
| cfg_tail_i | input | 1 | End-of-list flag for the written queue |
| req_i | input | 8 | Per-queue has-work request |
| next_i | input | 1 | Decision request pulse |
| gnt_valid_o | output | 1 | Grant strobe, one cycle after `next_i` |
| gnt_idx_o | output | 3 | Granted queue index |
| cfg_err_o | output | 1 | Previous write was rejected |

## Verification
A corrupted round counter or search start is visible at the first decision where two round-robin queues with different masks both request: `gnt_idx_o` names the wrong queue one cycle after that `next_i`. A corrupted weight table shows up more slowly. A wrong mask bit changes a grant only when its round is reached, which can take up to eight rounds. That is why the bench walks a full eight-round sequence with spread masks and then counts grant ratios per level. A wrong static flag or end-of-list flag is exposed at once, by a static queue losing to a round-robin one or by a queue past the list end being granted.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int LVL_W  = 4;
  localparam int MASK_W = 8;
  localparam int RND_W  = $clog2(MASK_W);
  localparam logic [LVL_W-1:0] LVL_STATIC = 4'd9;

  // Weight level to round participation mask; bits spread over the 8 rounds.
  function automatic logic [MASK_W-1:0] level_to_mask(input logic [LVL_W-1:0] lvl);
    logic [MASK_W-1:0] m;
    case (lvl)
      4'd1:    m = 8'h01;
      4'd2:    m = 8'h11;
      4'd3:    m = 8'h49;
      4'd4:    m = 8'h55;
      4'd5:    m = 8'h57;
      4'd6:    m = 8'h77;
      4'd7:    m = 8'h7f;
      4'd8:    m = 8'hff;
      4'd9:    m = 8'hff;
      default: m = 8'h00;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wrr_cfg_table.sv
module wrr_cfg_table
  import wrr_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QW = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [QW-1:0]                  wr_idx,
  input  logic [LVL_W-1:0]               wr_lvl,
  input  logic                           wr_tail,
  output logic [NQ-1:0][MASK_W-1:0]      mask_o,
  output logic [NQ-1:0]                  stat_o,
  output logic [NQ-1:0]                  act_o,
  output logic                           err_o
);
  logic [NQ-1:0][MASK_W-1:0] mask_q;
  logic [NQ-1:0]             stat_q;
  logic [NQ-1:0]             tail_q;
  logic                      err_q;
  logic [NQ-1:0]             stat_next;
  logic                      lvl_bad;
  logic                      shape_bad;
  logic                      accept;

  always_comb begin
    stat_next         = stat_q;
    stat_next[wr_idx] = (wr_lvl == LVL_STATIC);
    lvl_bad           = (wr_lvl > LVL_STATIC);
    shape_bad         = ((stat_next & (stat_next + NQ'(1))) != '0);
    accept            = wr_en && !lvl_bad && !shape_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      tail_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= wr_en && (lvl_bad || shape_bad);
      if (accept) begin
        mask_q[wr_idx] <= level_to_mask(wr_lvl);
        stat_q         <= stat_next;
        tail_q[wr_idx] <= wr_tail;
      end
    end
  end

  // A queue is in the list when no earlier queue carries the end flag.
  always_comb begin
    act_o[0] = 1'b1;
    for (int i = 1; i < NQ; i++) begin
      act_o[i] = act_o[i-1] & ~tail_q[i-1];
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign err_o  = err_q;

  // R6: static group always contiguous from queue 0
  assert_static_prefix_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_q & (stat_q + NQ'(1))) == '0);

  // R6: a flagged write left the table as it was
  assert_reject_keeps_table_R6: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($stable(mask_q) && $stable(stat_q) && $stable(tail_q)));
endmodule

// File: rtl/wrr_static_pick.sv
module wrr_static_pick #(
  parameter int NQ = 8,
  parameter int QW = 3
) (
  input  logic [NQ-1:0] cand_i,
  output logic          hit_o,
  output logic [QW-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (cand_i[q]) begin
        hit_o = 1'b1;
        idx_o = QW'(q);
      end
    end
  end
endmodule

// File: rtl/wrr_round_pick.sv
module wrr_round_pick
  import wrr_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QW = 3
) (
  input  logic [NQ-1:0]              cand_i,
  input  logic [NQ-1:0][MASK_W-1:0]  mask_i,
  input  logic [RND_W-1:0]           round_i,
  input  logic [QW-1:0]              start_i,
  output logic                       hit_o,
  output logic [QW-1:0]              idx_o,
  output logic [RND_W-1:0]           round_o
);
  localparam int NR = MASK_W;

  logic [RND_W-1:0] rsel;
  logic             in_win;

  // Window k=0: current round from start; k=1..NR-1: later rounds whole;
  // k=NR: current round below start. Reverse walk so the earliest hit stays.
  always_comb begin
    hit_o   = 1'b0;
    idx_o   = '0;
    round_o = round_i;
    rsel    = round_i;
    in_win  = 1'b0;
    for (int k = NR; k >= 0; k--) begin
      rsel = round_i + RND_W'(k);
      for (int q = NQ - 1; q >= 0; q--) begin
        if (k == 0)       in_win = (QW'(q) >= start_i);
        else if (k == NR) in_win = (QW'(q) < start_i);
        else              in_win = 1'b1;
        if (in_win && cand_i[q] && mask_i[q][rsel]) begin
          hit_o   = 1'b1;
          idx_o   = QW'(q);
          round_o = rsel;
        end
      end
    end
  end
endmodule

// File: rtl/wrr_queue_sched.sv
module wrr_queue_sched
  import wrr_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_i,
  input  logic [QW-1:0]    cfg_idx_i,
  input  logic [LVL_W-1:0] cfg_level_i,
  input  logic             cfg_tail_i,
  input  logic [NQ-1:0]    req_i,
  input  logic             next_i,
  output logic             gnt_valid_o,
  output logic [QW-1:0]    gnt_idx_o,
  output logic             cfg_err_o
);
  logic [NQ-1:0][MASK_W-1:0] mask_w;
  logic [NQ-1:0]             stat_w;
  logic [NQ-1:0]             act_w;
  logic [NQ-1:0]             s_cand;
  logic [NQ-1:0]             r_cand;
  logic                      s_hit, r_hit;
  logic [QW-1:0]             s_idx, r_idx;
  logic [RND_W-1:0]          r_round;
  logic [RND_W-1:0]          round_q;
  logic [QW-1:0]             start_q;
  logic                      gv_q;
  logic [QW-1:0]             gi_q;

  wrr_cfg_table #(.NQ(NQ), .QW(QW)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_i), .wr_idx(cfg_idx_i), .wr_lvl(cfg_level_i), .wr_tail(cfg_tail_i),
    .mask_o(mask_w), .stat_o(stat_w), .act_o(act_w), .err_o(cfg_err_o)
  );

  assign s_cand = req_i & act_w & stat_w;
  assign r_cand = req_i & act_w & ~stat_w;

  wrr_static_pick #(.NQ(NQ), .QW(QW)) u_static (
    .cand_i(s_cand), .hit_o(s_hit), .idx_o(s_idx)
  );

  wrr_round_pick #(.NQ(NQ), .QW(QW)) u_round (
    .cand_i(r_cand), .mask_i(mask_w), .round_i(round_q), .start_i(start_q),
    .hit_o(r_hit), .idx_o(r_idx), .round_o(r_round)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      round_q <= '0;
      start_q <= '0;
      gv_q    <= 1'b0;
      gi_q    <= '0;
    end else begin
      gv_q <= 1'b0;
      if (next_i) begin
        if (s_hit) begin
          gv_q <= 1'b1;
          gi_q <= s_idx;
        end else if (r_hit) begin
          gv_q <= 1'b1;
          gi_q <= r_idx;
          if (r_idx == QW'(NQ - 1)) begin
            start_q <= '0;
            round_q <= r_round + RND_W'(1);
          end else begin
            start_q <= r_idx + QW'(1);
            round_q <= r_round;
          end
        end
      end
    end
  end

  assign gnt_valid_o = gv_q;
  assign gnt_idx_o   = gi_q;

  // R4: a strobe only follows a decision pulse
  assert_grant_needs_next_R4: assert property (@(posedge clk) disable iff (rst)
    gnt_valid_o |-> $past(next_i));

  // R3: granted queue was requesting and in the list
  assert_grant_requested_R3: assert property (@(posedge clk) disable iff (rst)
    gnt_valid_o |-> ((($past(req_i & act_w) >> gnt_idx_o) & NQ'(1)) != '0));

  // R5: a requesting static queue forces a static grant
  assert_static_first_R5: assert property (@(posedge clk) disable iff (rst)
    (next_i && (|s_cand)) |=> (gnt_valid_o && ((($past(stat_w) >> gnt_idx_o) & NQ'(1)) != '0)));
endmodule

// File: tb/wrr_queue_sched_bench.sv
`timescale 1ns/1ps
module wrr_queue_sched_bench;
  localparam int NQ = 8;
  localparam int QW = 3;
  localparam int NV = 14;
  // {req[7:0], expected valid, expected index}
  localparam logic [11:0] VEC [NV] = '{
    {8'b0000_1111, 1'b1, 3'd0},
    {8'b0000_1110, 1'b1, 3'd1},
    {8'b0000_1110, 1'b1, 3'd2},
    {8'b0000_1110, 1'b1, 3'd3},
    {8'b0000_1110, 1'b1, 3'd2},
    {8'b0000_1110, 1'b1, 3'd2},
    {8'b0000_1110, 1'b1, 3'd2},
    {8'b0000_1110, 1'b1, 3'd3},
    {8'b0000_1110, 1'b1, 3'd1},
    {8'b0000_0100, 1'b1, 3'd2},
    {8'b0000_1001, 1'b1, 3'd0},
    {8'b0000_0000, 1'b0, 3'd0},
    {8'b0000_1000, 1'b1, 3'd3},
    {8'b0000_0010, 1'b1, 3'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [QW-1:0] cfg_idx = '0;
  logic [3:0] cfg_level = '0;
  logic cfg_tail = 1'b0;
  logic [NQ-1:0] req = '0;
  logic next = 1'b0;
  logic gnt_valid;
  logic [QW-1:0] gnt_idx;
  logic cfg_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wrr_queue_sched #(.NQ(NQ)) u_wrr_queue_sched (
    .clk(clk), .rst(rst),
    .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx), .cfg_level_i(cfg_level), .cfg_tail_i(cfg_tail),
    .req_i(req), .next_i(next),
    .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic cfg(input int idx, input int lvl, input bit tail, output logic err);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = QW'(idx); cfg_level = 4'(lvl); cfg_tail = tail;
    @(posedge clk);
    #1 err = cfg_err;
    cfg_wr = 1'b0;
  endtask

  task automatic decide(input logic [NQ-1:0] rq, output logic v, output logic [QW-1:0] ix);
    @(negedge clk);
    req = rq; next = 1'b1;
    @(posedge clk);
    #1 v = gnt_valid; ix = gnt_idx;
    next = 1'b0;
  endtask

  initial begin : main
    logic e, v;
    logic [QW-1:0] ix;
    int cnt;

    // R1: reset state
    do_reset();
    chk(gnt_valid == 1'b0, "R1 valid after reset", gnt_valid, 0);
    chk(cfg_err == 1'b0, "R1 err after reset", cfg_err, 0);
    decide(8'hff, v, ix);
    chk(v == 1'b0, "R1 no grant with all level 0", v, 0);

    // Scenario: q0 static, q1 level2, q2 level8, q3 level3 with end flag
    cfg(0, 9, 0, e); chk(e == 1'b0, "R6 valid static write", e, 0);
    cfg(1, 2, 0, e);
    cfg(2, 8, 0, e);
    cfg(3, 3, 1, e); chk(e == 1'b0, "R6 valid tail write", e, 0);

    // R2 R5 R7: table walk over eight rounds
    for (int n = 0; n < NV; n++) begin
      decide(VEC[n][11:4], v, ix);
      chk(v == VEC[n][3], $sformatf("R7 vector %0d valid", n), v, VEC[n][3]);
      if (VEC[n][3]) chk(ix == VEC[n][2:0], $sformatf("R7 vector %0d index", n), ix, VEC[n][2:0]);
    end

    // R4: strobe lasts one cycle
    @(posedge clk); #1;
    chk(gnt_valid == 1'b0, "R4 strobe drops", gnt_valid, 0);

    // R8: level 0 sole requester, change on the fly
    cfg(2, 0, 0, e);
    decide(8'b0000_0100, v, ix);
    chk(v == 1'b0, "R8 level 0 not granted", v, 0);
    cfg(2, 8, 0, e);

    // R3: queue past end flag ignored, then list extended
    cfg(5, 8, 0, e);
    decide(8'b0010_0000, v, ix);
    chk(v == 1'b0, "R3 past tail ignored", v, 0);
    cfg(3, 3, 0, e);
    cfg(5, 8, 1, e);
    decide(8'b0010_0000, v, ix);
    chk(v == 1'b1 && ix == 3'd5, "R3 extended list grant", ix, 5);

    // R5: static ordering
    cfg(1, 9, 0, e); chk(e == 1'b0, "R6 contiguous static ok", e, 0);
    decide(8'b0000_0110, v, ix);
    chk(v == 1'b1 && ix == 3'd1, "R5 static beats round robin", ix, 1);
    decide(8'b0000_0011, v, ix);
    chk(v == 1'b1 && ix == 3'd0, "R5 lowest static wins", ix, 0);

    // R6: rejected writes
    cfg(0, 2, 0, e); chk(e == 1'b1, "R6 static not from 0 flagged", e, 1);
    decide(8'b0000_0011, v, ix);
    chk(v == 1'b1 && ix == 3'd0, "R6 rejected write ignored", ix, 0);
    cfg(3, 9, 0, e); chk(e == 1'b1, "R6 gap in static flagged", e, 1);
    cfg(4, 12, 0, e); chk(e == 1'b1, "R6 bad level flagged", e, 1);
    cfg(1, 9, 0, e); chk(e == 1'b0, "R6 flag clears", e, 0);

    // R2: grant ratio per level against a level-8 partner
    for (int lv = 0; lv <= 8; lv++) begin
      do_reset();
      cfg(0, lv, 0, e);
      cfg(1, 8, 1, e);
      cnt = 0;
      for (int n = 0; n < lv + 8; n++) begin
        decide(8'b0000_0011, v, ix);
        if (v && ix == 3'd0) cnt++;
      end
      chk(cnt == lv, $sformatf("R2 level %0d share", lv), cnt, lv);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule